// File: doc/BRIEF.md
# Bidirectional Logical Shifter With Carry

This block is a 32-bit logical shift unit for a processor datapath. One signed shift amount sets both the direction and the distance. A positive amount moves the source word toward the high end, and a negative amount moves it toward the low end. An amount of zero passes the word through unchanged. In both directions the vacated positions fill with zeros. The last bit that leaves the word is kept as a carry flag.

The shift itself is combinational. The result word and the carry are captured in output registers on any clock edge where the enable strobe is high. The unit reads only the low seven bits of the count word. Operand fetch, register-file writeback and all flags other than carry are handled elsewhere.

Top module: `bidir_shifter`

## Requirements
- R1: Only bits 6:0 of `count_i` are used, read as a two's-complement value from -64 to +63; bits 31:7 have no effect on the result or the carry.
- R2: A count of zero gives a result equal to `src_i` and a carry of 0.
- R3: A count n from 1 to 31 gives `src_i` shifted toward bit 31 by n places with zeros entering at bit 0; the carry equals `src_i[32-n]`.
- R4: A count of -m, with m from 1 to 31, gives `src_i` shifted toward bit 0 by m places with zeros entering at bit 31; the carry equals `src_i[m-1]`.
- R5: A magnitude of 32 or more gives an all-zero result. The carry is `src_i[0]` for +32, `src_i[31]` for -32, and 0 for any magnitude above 32, which includes -64.
- R6: The result and the carry load at the rising clock edge where `en` is 1 and appear after that edge. While `en` is 0 they keep their value, whatever the data inputs do.
- R7: A synchronous active-high `rst` clears the result and the carry to 0 and takes priority over `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load strobe for the result and carry registers |
| src_i | input | 32 | Unsigned source word |
| count_i | input | 32 | Shift count; the signed value is in bits 6:0 |
| result_o | output | 32 | Registered unsigned result |
| carry_o | output | 1 | Registered last bit shifted out |

## Verification
The hardest case to reach is the carry at the edges of the count range. At +32 and -32 the last bit out is a far-end bit of the source. At -64 the seven-bit code is the most negative value, and its magnitude does not fit the positive range. The bench applies all 128 count codes against a set of source patterns, including single-bit and alternating words, so that the carry comes from each position in turn. It repeats the sweep with random and all-ones upper count bits to show that bits 31:7 are ignored. The expected values come from a one-place-at-a-time reference that uses no barrel structure.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  localparam int unsigned DATA_W_DEF = 32;
  localparam int unsigned CNT_W_DEF  = 7;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2
  } shdir_e;
endpackage

// File: rtl/count_decode.sv
module count_decode
  import lsh_pkg::*;
#(
  parameter int unsigned CW = CNT_W_DEF
) (
  input  logic [CW-1:0] field_i,
  output shdir_e        dir_o,
  output logic [CW-1:0] mag_o
);
  // Magnitude of a two's-complement field. The most negative code maps to
  // 2**(CW-1), which still fits CW unsigned bits.
  function automatic logic [CW-1:0] abs_mag(input logic [CW-1:0] f);
    logic [CW-1:0] one;
    one = {{(CW-1){1'b0}}, 1'b1};
    if (f[CW-1]) return (~f) + one;
    return f;
  endfunction

  logic is_neg;
  logic is_zero;

  assign is_neg  = field_i[CW-1];
  assign is_zero = (field_i == '0);
  assign mag_o   = abs_mag(field_i);

  always_comb begin
    if (is_zero)     dir_o = SH_NONE;
    else if (is_neg) dir_o = SH_RIGHT;
    else             dir_o = SH_LEFT;
  end
endmodule

// File: rtl/shift_stages.sv
module shift_stages #(
  parameter int unsigned W    = 33,
  parameter int unsigned SW   = 7,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] st [0:SW];

  assign st[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    if (SH >= W) begin : g_flush
      assign st[k+1] = amt[k] ? '0 : st[k];
    end else if (LEFT) begin : g_left
      assign st[k+1] = amt[k] ? {st[k][W-1-SH:0], {SH{1'b0}}} : st[k];
    end else begin : g_right
      assign st[k+1] = amt[k] ? {{SH{1'b0}}, st[k][W-1:SH]} : st[k];
    end
  end

  assign dout = st[SW];
endmodule

// File: rtl/shifter_core.sv
module shifter_core
  import lsh_pkg::*;
#(
  parameter int unsigned DW = DATA_W_DEF,
  parameter int unsigned CW = CNT_W_DEF
) (
  input  logic [DW-1:0] src_i,
  input  shdir_e        dir_i,
  input  logic [CW-1:0] mag_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  localparam int unsigned XW = DW + 1;

  // One guard bit beyond the word catches the last bit to leave: above the
  // MSB for left shifts and below the LSB for right shifts.
  logic [XW-1:0] left_in, right_in, left_out, right_out;

  assign left_in  = {1'b0, src_i};
  assign right_in = {src_i, 1'b0};

  shift_stages #(.W(XW), .SW(CW), .LEFT(1'b1)) u_left (
    .din (left_in),
    .amt (mag_i),
    .dout(left_out)
  );

  shift_stages #(.W(XW), .SW(CW), .LEFT(1'b0)) u_right (
    .din (right_in),
    .amt (mag_i),
    .dout(right_out)
  );

  always_comb begin
    unique case (dir_i)
      SH_LEFT: begin
        res_o   = left_out[DW-1:0];
        carry_o = left_out[XW-1];
      end
      SH_RIGHT: begin
        res_o   = right_out[XW-1:1];
        carry_o = right_out[0];
      end
      default: begin
        res_o   = src_i;
        carry_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bidir_shifter.sv
module bidir_shifter
  import lsh_pkg::*;
#(
  parameter int unsigned DW = DATA_W_DEF,
  parameter int unsigned CW = CNT_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] count_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  shdir_e        sh_dir;
  logic [CW-1:0] sh_mag;
  logic [DW-1:0] core_res;
  logic          core_carry;
  logic          sh_beyond;
  logic          cnt_unused_hi;

  assign cnt_unused_hi = ^count_i[DW-1:CW];
  assign sh_beyond     = (int'(sh_mag) > int'(DW));

  count_decode #(.CW(CW)) u_dec (
    .field_i(count_i[CW-1:0]),
    .dir_o  (sh_dir),
    .mag_o  (sh_mag)
  );

  shifter_core #(.DW(DW), .CW(CW)) u_core (
    .src_i  (src_i),
    .dir_i  (sh_dir),
    .mag_i  (sh_mag),
    .res_o  (core_res),
    .carry_o(core_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else if (en) begin
      result_o <= core_res;
      carry_o  <= core_carry;
    end
  end

  // R2: a zero count passes the source through and clears the carry
  a_r2_zero_pass : assert property (@(posedge clk) disable iff (rst)
    (en && sh_dir == SH_NONE) |=> (result_o == $past(src_i) && !carry_o));

  // R3: a left shift always leaves a zero in bit 0
  a_r3_low_fill : assert property (@(posedge clk) disable iff (rst)
    (en && sh_dir == SH_LEFT) |=> (result_o[0] == 1'b0));

  // R4: a right shift always leaves a zero in the top bit
  a_r4_high_fill : assert property (@(posedge clk) disable iff (rst)
    (en && sh_dir == SH_RIGHT) |=> (result_o[DW-1] == 1'b0));

  // R5: a magnitude beyond the word width empties the result and the carry
  a_r5_beyond_width : assert property (@(posedge clk) disable iff (rst)
    (en && sh_beyond) |=> (result_o == '0 && !carry_o));

  // R6: with the strobe low the outputs hold
  a_r6_hold : assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result_o) && $stable(carry_o)));

  // R7: the outputs are clear on the first cycle after reset is released
  a_r7_reset_clear : assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (result_o == '0 && !carry_o));
endmodule

// File: tb/bidir_shifter_tb.sv
module bidir_shifter_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [31:0] src;
  logic [31:0] cnt;
  logic [31:0] result;
  logic        carry;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bidir_shifter dut_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .src_i   (src),
    .count_i (cnt),
    .result_o(result),
    .carry_o (carry)
  );

  // Reference: move one place at a time, keeping the bit that falls off.
  task automatic ref_shift(input logic [31:0] s, input logic [6:0] c7,
                           output logic [31:0] r, output logic cy);
    int n;
    n  = int'($signed(c7));
    r  = s;
    cy = 1'b0;
    if (n > 0) begin
      for (int i = 0; i < n; i++) begin
        cy = r[31];
        r  = r << 1;
      end
    end else if (n < 0) begin
      for (int i = 0; i < -n; i++) begin
        cy = r[0];
        r  = r >> 1;
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] er, input logic ec);
    vectors++;
    if (result !== er || carry !== ec) begin
      misses++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result, carry, er, ec);
    end
  endtask

  function automatic string tag_of(input logic [6:0] c7);
    int n;
    n = int'($signed(c7));
    if (n == 0) return "R2";
    if (n >= 32 || n <= -32) return "R5";
    if (n > 0) return "R3";
    return "R4";
  endfunction

  task automatic apply(input logic [31:0] s, input logic [31:0] cw, input string req);
    logic [31:0] er;
    logic        ec;
    @(negedge clk);
    src = s; cnt = cw; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    ref_shift(s, cw[6:0], er, ec);
    check(req, er, ec);
  endtask

  logic [31:0] pats [0:9];

  initial begin
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'hAAAA_AAAA;
    pats[4] = 32'h5555_5555; pats[5] = 32'h1234_5678;
    pats[6] = 32'hDEAD_BEEF; pats[7] = 32'h8000_0001;
    pats[8] = 32'h7FFF_FFFE; pats[9] = 32'h0001_0000;

    rst = 1'b1; en = 1'b0; src = '0; cnt = '0;
    repeat (3) @(negedge clk);
    // R7: outputs clear under reset
    check("R7", 32'h0, 1'b0);
    rst = 1'b0;

    // R2..R5: every count code against every pattern, upper bits zero
    for (int p = 0; p < 10; p++)
      for (int c = -64; c < 64; c++) begin
        logic [6:0] c7;
        c7 = 7'(c);
        apply(pats[p], {25'b0, c7}, tag_of(c7));
      end

    // R1: upper count bits random, then all ones
    for (int p = 0; p < 10; p++)
      for (int c = -64; c < 64; c++) begin
        logic [6:0] c7;
        c7 = 7'(c);
        apply(pats[p], {25'($urandom), c7}, "R1");
        apply(pats[p], {25'h1FF_FFFF, c7}, "R1");
      end

    // R1: a count of 128 reads as zero, so it passes through with no carry
    apply(32'hCAFE_F00D, 32'h0000_0080, "R1");

    // R6: with the strobe low, changed inputs do not reach the outputs
    begin
      logic [31:0] er;
      logic        ec;
      apply(32'hF0F0_1234, 32'd4, "R6");
      ref_shift(32'hF0F0_1234, 7'd4, er, ec);
      @(negedge clk);
      src = 32'h0BAD_0BAD; cnt = 32'h7F;
      repeat (3) @(negedge clk);
      check("R6", er, ec);
    end

    // R7: reset wins over the strobe and clears a non-zero state
    apply(32'hFFFF_FFFF, 32'd1, "R3");
    @(negedge clk);
    rst = 1'b1; en = 1'b1; src = 32'h1111_1111; cnt = 32'd2;
    @(negedge clk);
    check("R7", 32'h0, 1'b0);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule